// File: doc/BRIEF.md
# PCI-to-ISA Bridge Configuration Register Space

This block holds the 256-byte configuration register space of a PCI-to-ISA bridge function. A configuration access gives a byte offset, a length of one to four bytes and, for a write, a 32-bit data word. Reads gather consecutive bytes into a little-endian word. Writes scatter the data word across consecutive bytes, one byte lane for each byte.

The space has two initialisation phases. A power-up reset clears every byte, loads the fixed identification and class-code bytes, and applies the function defaults. A function reset reloads only the per-offset defaults and leaves every other byte as it was. The status byte at offset 0x06 cannot be changed by configuration writes.

Top module: `bridge_cfg_space`

## Requirements
- R1: While `por_n` is low, every byte becomes 0x00. The exceptions are the identification bytes 0x00=0x86, 0x01=0x80, 0x03=0x70, 0x0A=0x01, 0x0B=0x06 and 0x0E=0x80, and the R2 defaults. `rdata` becomes 0.
- R2: While `rst_n` is low and `por_n` is high, these defaults are loaded: 0x04=0x07, 0x07=0x02, 0x4C=0x4D, 0x4E=0x03, 0x60=0x80, 0x69=0x02, 0x70=0x80, 0x76=0x0C, 0x77=0x0C, 0x78=0x02, 0xA0=0x08 and 0xA8=0x0F. The following offsets are loaded with 0x00: 0x05, 0x06, 0x4F, 0x79, 0x80, 0x82, 0xA2 to 0xA7, 0xAA, 0xAB, 0xAC and 0xAE. All other bytes keep their contents, including the identification bytes.
- R3: A read strobe with `len` from 1 to 4 puts byte offset+i on `rdata[8i+7:8i]`. Lanes at i >= `len` read 0x00. `rdata` is valid on the cycle after the strobe and holds its value until the next read strobe.
- R4: A read with `len` greater than 4 returns 0xFFFFFFFF. A read with `len` = 0 returns 0.
- R5: A write with `len` greater than 4, or with `len` = 0, changes no byte.
- R6: A write with `len` from 1 to 4 sets byte offset+i to `wdata[8i+7:8i]` for every i < `len`. The bytes change on the clock edge that samples the strobe.
- R7: A write lane that lands on offset 0x06 is discarded. The other lanes of the same access still update.
- R8: The identification bytes can be changed by configuration writes.
- R9: A lane whose offset+i is greater than 0xFF is dropped on a write and reads as 0xFF.
- R10: When a read and a write are strobed in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, synchronous |
| rst_n | input | 1 | Function reset, active low, synchronous |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Starting byte offset |
| len | input | 3 | Access length in bytes |
| wdata | input | 32 | Write data, little-endian lanes |
| rdata | output | 32 | Registered read data |

## Verification
The assertions check the following on every cycle outside reset:
- the status byte at 0x06 never changes;
- an oversize read returns all ones;
- `rdata` holds its value between read strobes;
- a single-byte write lands in its byte;
- an oversize write leaves the addressed byte alone.

Other behaviour can only be shown by the bench's scenarios:
- the two reset phases and how they differ;
- little-endian packing of multi-byte accesses;
- truncation past 0xFF;
- the partial write that straddles 0x06;
- read-before-write ordering in a shared cycle.

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space #(
  parameter int ADDR_W     = 8,
  parameter int DATA_BYTES = 4,
  parameter int LEN_W      = 3,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h06
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LEN_W-1:0]        len,
  input  logic [8*DATA_BYTES-1:0] wdata,
  output logic [8*DATA_BYTES-1:0] rdata
);
  localparam int NBYTES = 1 << ADDR_W;
  localparam int DW     = 8 * DATA_BYTES;

  logic [7:0] mem [NBYTES];
  logic [DW-1:0] rd_word;
  logic [ADDR_W:0] lane_off [DATA_BYTES];
  logic len_ok;

  function automatic logic [8:0] dflt(input int idx);
    case (idx)
      'h04: return 9'h107;
      'h07: return 9'h102;
      'h4C: return 9'h14D;
      'h4E: return 9'h103;
      'h60: return 9'h180;
      'h69: return 9'h102;
      'h70: return 9'h180;
      'h76, 'h77: return 9'h10C;
      'h78: return 9'h102;
      'hA0: return 9'h108;
      'hA8: return 9'h10F;
      'h05, 'h06, 'h4F, 'h79, 'h80, 'h82,
      'hA2, 'hA3, 'hA4, 'hA5, 'hA6, 'hA7,
      'hAA, 'hAB, 'hAC, 'hAE: return 9'h100;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [7:0] ident(input int idx);
    case (idx)
      'h00: return 8'h86;
      'h01: return 8'h80;
      'h03: return 8'h70;
      'h0A: return 8'h01;
      'h0B: return 8'h06;
      'h0E: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  assign len_ok = (len <= LEN_W'(DATA_BYTES));

  for (genvar l = 0; l < DATA_BYTES; l++) begin : g_lane
    assign lane_off[l] = {1'b0, addr} + (ADDR_W+1)'(l);
    assign rd_word[8*l +: 8] =
      (LEN_W'(l) >= len)      ? 8'h00 :
      lane_off[l][ADDR_W]     ? 8'hFF :
                                mem[lane_off[l][ADDR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      for (int i = 0; i < NBYTES; i++) begin
        logic [8:0] d;
        d = dflt(i);
        mem[i] <= d[8] ? d[7:0] : ident(i);
      end
    end else if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) begin
        logic [8:0] d;
        d = dflt(i);
        if (d[8]) mem[i] <= d[7:0];
      end
    end else if (wr_en && len_ok) begin
      for (int l = 0; l < DATA_BYTES; l++) begin
        if (LEN_W'(l) < len && !lane_off[l][ADDR_W] &&
            lane_off[l][ADDR_W-1:0] != STAT_OFS)
          mem[lane_off[l][ADDR_W-1:0]] <= wdata[8*l +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) rdata <= '0;
    else if (rd_en)       rdata <= len_ok ? rd_word : '1;
  end

  p_stat_lock_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    1'b1 |=> mem[STAT_OFS] == $past(mem[STAT_OFS]));

  p_oversize_rd_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (rd_en && !len_ok) |=> rdata == '1);

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !rd_en |=> $stable(rdata));

  p_byte_wr_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_en && len == LEN_W'(1) && addr != STAT_OFS) |=> mem[$past(addr)] == $past(wdata[7:0]));

  p_oversize_wr_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_en && !len_ok) |=> mem[$past(addr)] == $past(mem[addr]));
endmodule

// File: tb/bridge_cfg_space_test.sv
module bridge_cfg_space_test;
  logic clk = 0, por_n = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [2:0] len = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bridge_cfg_space uut (.clk(clk), .por_n(por_n), .rst_n(rst_n), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .len(len), .wdata(wdata), .rdata(rdata));

  // {is_write, offset, length, write data, expected read data}
  localparam int NV = 28;
  localparam logic [75:0] VEC [NV] = '{
    {1'b0, 8'h00, 3'd4, 32'h0, 32'h70008086},   // R1
    {1'b0, 8'h04, 3'd4, 32'h0, 32'h02000007},   // R2
    {1'b0, 8'h08, 3'd4, 32'h0, 32'h06010000},   // R1
    {1'b0, 8'h0C, 3'd4, 32'h0, 32'h00800000},   // R1
    {1'b0, 8'h4C, 3'd4, 32'h0, 32'h0003004D},   // R2
    {1'b0, 8'h76, 3'd3, 32'h0, 32'h00020C0C},   // R3
    {1'b0, 8'hA8, 3'd1, 32'h0, 32'h0000000F},   // R2
    {1'b0, 8'h60, 3'd2, 32'h0, 32'h00000080},   // R2
    {1'b1, 8'h40, 3'd4, 32'hDEADBEEF, 32'h0},   // R6
    {1'b0, 8'h40, 3'd4, 32'h0, 32'hDEADBEEF},   // R6
    {1'b0, 8'h41, 3'd2, 32'h0, 32'h0000ADBE},   // R3
    {1'b0, 8'h40, 3'd1, 32'h0, 32'h000000EF},   // R3
    {1'b1, 8'h04, 3'd4, 32'h11223344, 32'h0},   // R7
    {1'b0, 8'h04, 3'd4, 32'h0, 32'h11003344},   // R7
    {1'b1, 8'h06, 3'd1, 32'h000000FF, 32'h0},   // R7
    {1'b0, 8'h06, 3'd1, 32'h0, 32'h00000000},   // R7
    {1'b1, 8'h50, 3'd5, 32'hAAAAAAAA, 32'h0},   // R5
    {1'b0, 8'h50, 3'd4, 32'h0, 32'h00000000},   // R5
    {1'b1, 8'h54, 3'd0, 32'hBBBBBBBB, 32'h0},   // R5
    {1'b0, 8'h54, 3'd4, 32'h0, 32'h00000000},   // R5
    {1'b0, 8'h50, 3'd7, 32'h0, 32'hFFFFFFFF},   // R4
    {1'b0, 8'h00, 3'd0, 32'h0, 32'h00000000},   // R4
    {1'b1, 8'hFE, 3'd4, 32'h55667788, 32'h0},   // R9
    {1'b0, 8'hFE, 3'd4, 32'h0, 32'hFFFF7788},   // R9
    {1'b0, 8'hFF, 3'd1, 32'h0, 32'h00000077},   // R9
    {1'b0, 8'h00, 3'd4, 32'h0, 32'h70008086},   // R8 pre
    {1'b1, 8'h00, 3'd2, 32'h0000BEEF, 32'h0},   // R8
    {1'b0, 8'h00, 3'd4, 32'h0, 32'h7000BEEF}    // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; len = l; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [2:0] l, output logic [31:0] r);
    @(negedge clk); rd_en = 1; addr = a; len = l;
    @(negedge clk); rd_en = 0; r = rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    check("R1 rdata after power-up", rdata, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][75]) do_wr(VEC[v][74:67], VEC[v][66:64], VEC[v][63:32]);
      else begin
        do_rd(VEC[v][74:67], VEC[v][66:64], r);
        check($sformatf("R3/R6 vector %0d", v), r, VEC[v][31:0]);
      end
    end

    // R3 hold between strobes
    repeat (4) @(negedge clk);
    check("R3 hold", rdata, 32'h7000BEEF);

    // R2 function reset keeps identification and other bytes
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    do_rd(8'h00, 3'd4, r); check("R2 id kept", r, 32'h7000BEEF);
    do_rd(8'h04, 3'd4, r); check("R2 cmd default", r, 32'h02000007);
    do_rd(8'h40, 3'd4, r); check("R2 other kept", r, 32'hDEADBEEF);
    do_rd(8'hFE, 3'd2, r); check("R2 top kept", r, 32'h00007788);

    // R1 power-up reset reloads identification and clears
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
    do_rd(8'h00, 3'd4, r); check("R1 id reload", r, 32'h70008086);
    do_rd(8'h40, 3'd4, r); check("R1 cleared", r, 32'h0);
    do_rd(8'hA0, 3'd1, r); check("R1 defaults", r, 32'h08);

    // R10 read and write in the same cycle
    @(negedge clk); rd_en = 1; wr_en = 1; addr = 8'h90; len = 3'd1; wdata = 32'h5A;
    @(negedge clk); rd_en = 0; wr_en = 0;
    check("R10 old data", rdata, 32'h0);
    do_rd(8'h90, 3'd1, r); check("R10 new data", r, 32'h5A);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule